// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block keeps the fetch state of every hardware thread in a multithreaded front end and moves it forward once per clock. The inputs are control signals that come back from later pipeline stages. Four of those stages, decode, rename, execute and commit, can each raise a block pulse or an unblock pulse for any thread. Commit and decode can each ask for a squash. Commit can also report that its reorder buffer is still squashing. A single global context-switch stall applies to all threads. The instruction-cache side reports when a thread starts a miss, when a response arrives, and when the fetch unit tries a thread again.

Each thread stores four stall bits. Every cycle the thread picks its next state through a fixed priority. A commit squash comes first, then an ongoing reorder-buffer squash, then a decode squash, then a stall, and last the return to Running. Only after these are the cache events handled.

The block has two summary outputs. A status-changed flag tells the surrounding pipeline that some thread's rule fired. A stage-active flag says whether any enabled thread still has fetch work to do. Only threads whose bit in `thr_active` is set take part. The other threads keep their state and their stall bits unchanged. All inputs are plain level signals that are sampled on each clock, so the block has no handshake.

Top module: `fsc_fetch_status`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) puts every thread in Running with all four stall bits clear, and `status_chg` low. After reset, an idle cycle leaves every thread in Running.
- R2: Each thread has four stall bits, one for each of decode, rename, execute and commit. The block pulse for a source sets that source's bit and the unblock pulse clears it. Each bit is independent of the others. A thread with any stall bit set goes to Blocked, and the bits updated in the same cycle are already taken into account. A block pulse and an unblock pulse for the same source and thread must never arrive in the same cycle.
- R3: While `ctx_stall` is high, every active thread that is not waiting on a cache response goes to Blocked.
- R4: A commit squash has the highest priority. It puts the thread in Squashing, whatever decode squash, stall or cache event arrives in the same cycle.
- R5: When there is no commit squash, a high `rob_squashing` keeps the thread in Squashing, or puts it there. This overrides decode squash and stalls.
- R6: A decode squash puts a thread in Squashing only when the thread is not already in Squashing. When the thread is already in Squashing, the decode squash is ignored and the lower-priority rules decide the next state.
- R7: A thread in Blocked or Squashing that receives no squash and has no stall returns to Running.
- R8: `miss_start` moves a Running thread to WaitResponse. A thread in WaitResponse stays there through stalls until its response arrives or a squash hits it.
- R9: A response (`resp_valid`) that reaches a thread in WaitResponse moves the thread to Blocked if the thread is stalled, and to AccessComplete if it is not. A response that reaches a thread in any other state is ignored.
- R10: A thread in AccessComplete moves to Running when `fetch_try` is high.
- R11: A thread whose `thr_active` bit is low keeps its state and its stall bits, whatever its other inputs do.
- R12: `status_chg` is registered. It is high in the cycle after an edge at which any active thread's rule fired: any squash, any entry to or repeat of Blocked, a return to Running, or a cache event. It is low otherwise.
- R13: `stage_active` is high exactly when some active thread is in Running, Squashing or AccessComplete. State codes on `thr_state` are Running=0, Idle=1, Squashing=2, Blocked=3, WaitResponse=4, WaitRetry=5, AccessComplete=6 and TrapPending=7. Thread t occupies bits [3t+2:3t].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| thr_active | input | NUM_THREADS | Thread takes part this cycle |
| dec_blk | input | NUM_THREADS | Decode block pulse per thread |
| dec_unblk | input | NUM_THREADS | Decode unblock pulse per thread |
| ren_blk | input | NUM_THREADS | Rename block pulse per thread |
| ren_unblk | input | NUM_THREADS | Rename unblock pulse per thread |
| exe_blk | input | NUM_THREADS | Execute block pulse per thread |
| exe_unblk | input | NUM_THREADS | Execute unblock pulse per thread |
| cmt_blk | input | NUM_THREADS | Commit block pulse per thread |
| cmt_unblk | input | NUM_THREADS | Commit unblock pulse per thread |
| cmt_squash | input | NUM_THREADS | Squash request from commit |
| rob_squashing | input | NUM_THREADS | Reorder buffer still squashing |
| dec_squash | input | NUM_THREADS | Squash request from decode |
| ctx_stall | input | 1 | Global context-switch stall |
| miss_start | input | NUM_THREADS | Thread issued a cache miss |
| resp_valid | input | NUM_THREADS | Cache response for the thread |
| fetch_try | input | NUM_THREADS | Fetch attempt for the thread |
| thr_state | output | 3*NUM_THREADS | Packed per-thread state codes |
| status_chg | output | 1 | A thread rule fired at the last edge |
| stage_active | output | 1 | Stage has fetch work pending |

## Verification
The bench looks at the cycles in which several rules compete, for example a commit squash arriving together with a decode squash and a new block. A design with the priority inverted would show Blocked where Squashing is expected. It repeats a decode squash on a thread that is already in Squashing. A design that acts on it would stay in Squashing instead of returning to Running. It stalls a thread while a cache response is outstanding and then sends responses both to waiting threads and to threads that are not waiting. A design with the wrong exception would lose the pending response or invent an AccessComplete state. It also drives block pulses and squashes at threads whose active bit is low and checks that nothing is latched. It checks that releasing one of two stall sources keeps the thread in Blocked, which catches a design that folds the four sources into a single bit.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

  typedef enum logic [2:0] {
    FS_RUN       = 3'd0,
    FS_IDLE      = 3'd1,
    FS_SQUASH    = 3'd2,
    FS_BLOCK     = 3'd3,
    FS_WAIT_RESP = 3'd4,
    FS_WAIT_RTRY = 3'd5,
    FS_ACC_DONE  = 3'd6,
    FS_TRAP      = 3'd7
  } fs_state_e;

  localparam int FS_W = $bits(fs_state_e);

  // stall source slots within a thread's stall vector
  localparam int NUM_SRC = 4;
  localparam int SRC_DEC = 0;
  localparam int SRC_REN = 1;
  localparam int SRC_EXE = 2;
  localparam int SRC_CMT = 3;

endpackage

// File: rtl/fsc_stall_latch.sv
module fsc_stall_latch #(
  parameter int N_SRC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [N_SRC-1:0] blk,
  input  logic [N_SRC-1:0] unblk,
  output logic             any_nxt
);

  logic [N_SRC-1:0] bits_q;
  logic [N_SRC-1:0] bits_nxt;

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    // an unblock clears, a block sets; both never arrive together
    always_comb begin
      bits_nxt[s] = bits_q[s];
      if (en) begin
        if (blk[s])   bits_nxt[s] = 1'b1;
        if (unblk[s]) bits_nxt[s] = 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) bits_q[s] <= 1'b0;
      else     bits_q[s] <= bits_nxt[s];
    end
  end

  assign any_nxt = |bits_nxt;

endmodule

// File: rtl/fsc_thread_fsm.sv
module fsc_thread_fsm
  import fsc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      en,
  input  logic      stalled,
  input  logic      cmt_sq,
  input  logic      rob_sq,
  input  logic      dec_sq,
  input  logic      miss,
  input  logic      resp,
  input  logic      ftry,
  output fs_state_e state,
  output logic      fired
);

  fs_state_e st_q;
  fs_state_e st_nxt;

  always_comb begin
    st_nxt = st_q;
    fired  = 1'b0;
    if (en) begin
      if (cmt_sq) begin
        st_nxt = FS_SQUASH;
        fired  = 1'b1;
      end else if (rob_sq) begin
        st_nxt = FS_SQUASH;
        fired  = 1'b1;
      end else if (dec_sq && st_q != FS_SQUASH) begin
        st_nxt = FS_SQUASH;
        fired  = 1'b1;
      end else if (stalled && st_q != FS_WAIT_RESP) begin
        st_nxt = FS_BLOCK;
        fired  = 1'b1;
      end else if (st_q == FS_BLOCK || st_q == FS_SQUASH) begin
        st_nxt = FS_RUN;
        fired  = 1'b1;
      end else if (st_q == FS_WAIT_RESP && resp) begin
        st_nxt = stalled ? FS_BLOCK : FS_ACC_DONE;
        fired  = 1'b1;
      end else if (st_q == FS_ACC_DONE && ftry) begin
        st_nxt = FS_RUN;
        fired  = 1'b1;
      end else if (st_q == FS_RUN && miss) begin
        st_nxt = FS_WAIT_RESP;
        fired  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= FS_RUN;
    else     st_q <= st_nxt;
  end

  assign state = st_q;

endmodule

// File: rtl/fsc_activity.sv
module fsc_activity
  import fsc_pkg::*;
#(
  parameter int NUM_THREADS = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_THREADS*FS_W-1:0] states,
  input  logic [NUM_THREADS-1:0]      act,
  input  logic [NUM_THREADS-1:0]      fired,
  output logic                        status_chg,
  output logic                        stage_active
);

  logic [NUM_THREADS-1:0] busy;

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_busy
    logic [FS_W-1:0] s;
    assign s = states[t*FS_W +: FS_W];
    assign busy[t] = act[t] &&
                     (s == FS_RUN || s == FS_SQUASH || s == FS_ACC_DONE);
  end

  assign stage_active = |busy;

  always_ff @(posedge clk) begin
    if (rst) status_chg <= 1'b0;
    else     status_chg <= |fired;
  end

endmodule

// File: rtl/fsc_fetch_status.sv
module fsc_fetch_status
  import fsc_pkg::*;
#(
  parameter int NUM_THREADS = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_THREADS-1:0]      thr_active,
  input  logic [NUM_THREADS-1:0]      dec_blk,
  input  logic [NUM_THREADS-1:0]      dec_unblk,
  input  logic [NUM_THREADS-1:0]      ren_blk,
  input  logic [NUM_THREADS-1:0]      ren_unblk,
  input  logic [NUM_THREADS-1:0]      exe_blk,
  input  logic [NUM_THREADS-1:0]      exe_unblk,
  input  logic [NUM_THREADS-1:0]      cmt_blk,
  input  logic [NUM_THREADS-1:0]      cmt_unblk,
  input  logic [NUM_THREADS-1:0]      cmt_squash,
  input  logic [NUM_THREADS-1:0]      rob_squashing,
  input  logic [NUM_THREADS-1:0]      dec_squash,
  input  logic                        ctx_stall,
  input  logic [NUM_THREADS-1:0]      miss_start,
  input  logic [NUM_THREADS-1:0]      resp_valid,
  input  logic [NUM_THREADS-1:0]      fetch_try,
  output logic [NUM_THREADS*FS_W-1:0] thr_state,
  output logic                        status_chg,
  output logic                        stage_active
);

  logic [NUM_THREADS-1:0] fired;

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    logic [NUM_SRC-1:0] blk_v;
    logic [NUM_SRC-1:0] unblk_v;
    logic               any_stall;
    fs_state_e          st;

    always_comb begin
      blk_v            = '0;
      unblk_v          = '0;
      blk_v[SRC_DEC]   = dec_blk[t];
      blk_v[SRC_REN]   = ren_blk[t];
      blk_v[SRC_EXE]   = exe_blk[t];
      blk_v[SRC_CMT]   = cmt_blk[t];
      unblk_v[SRC_DEC] = dec_unblk[t];
      unblk_v[SRC_REN] = ren_unblk[t];
      unblk_v[SRC_EXE] = exe_unblk[t];
      unblk_v[SRC_CMT] = cmt_unblk[t];
    end

    fsc_stall_latch #(.N_SRC(NUM_SRC)) u_stall (
      .clk     (clk),
      .rst     (rst),
      .en      (thr_active[t]),
      .blk     (blk_v),
      .unblk   (unblk_v),
      .any_nxt (any_stall)
    );

    fsc_thread_fsm u_fsm (
      .clk     (clk),
      .rst     (rst),
      .en      (thr_active[t]),
      .stalled (any_stall | ctx_stall),
      .cmt_sq  (cmt_squash[t]),
      .rob_sq  (rob_squashing[t]),
      .dec_sq  (dec_squash[t]),
      .miss    (miss_start[t]),
      .resp    (resp_valid[t]),
      .ftry    (fetch_try[t]),
      .state   (st),
      .fired   (fired[t])
    );

    assign thr_state[t*FS_W +: FS_W] = st;
  end

  fsc_activity #(.NUM_THREADS(NUM_THREADS)) u_act (
    .clk          (clk),
    .rst          (rst),
    .states       (thr_state),
    .act          (thr_active),
    .fired        (fired),
    .status_chg   (status_chg),
    .stage_active (stage_active)
  );

endmodule

// File: rtl/fsc_fetch_status_chk.sv
module fsc_fetch_status_chk
  import fsc_pkg::*;
#(
  parameter int NUM_THREADS = 4
) (
  input logic                        clk,
  input logic                        rst,
  input logic [NUM_THREADS-1:0]      thr_active,
  input logic [NUM_THREADS-1:0]      dec_blk,
  input logic [NUM_THREADS-1:0]      dec_unblk,
  input logic [NUM_THREADS-1:0]      ren_blk,
  input logic [NUM_THREADS-1:0]      ren_unblk,
  input logic [NUM_THREADS-1:0]      exe_blk,
  input logic [NUM_THREADS-1:0]      exe_unblk,
  input logic [NUM_THREADS-1:0]      cmt_blk,
  input logic [NUM_THREADS-1:0]      cmt_unblk,
  input logic [NUM_THREADS-1:0]      cmt_squash,
  input logic [NUM_THREADS-1:0]      rob_squashing,
  input logic [NUM_THREADS-1:0]      dec_squash,
  input logic                        ctx_stall,
  input logic [NUM_THREADS-1:0]      resp_valid,
  input logic [NUM_THREADS*FS_W-1:0] thr_state,
  input logic                        status_chg
);

  // R2
  blk_unblk_excl_chk: assert property (@(posedge clk) disable iff (rst)
    ((dec_blk & dec_unblk) | (ren_blk & ren_unblk) |
     (exe_blk & exe_unblk) | (cmt_blk & cmt_unblk)) == '0);

  // R12
  state_move_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (thr_state != $past(thr_state)) |-> status_chg);

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_chk
    // R4
    cmt_squash_wins_chk: assert property (@(posedge clk) disable iff (rst)
      (thr_active[t] && cmt_squash[t])
      |=> thr_state[t*FS_W +: FS_W] == FS_SQUASH);

    // R5
    rob_squash_holds_chk: assert property (@(posedge clk) disable iff (rst)
      (thr_active[t] && rob_squashing[t])
      |=> thr_state[t*FS_W +: FS_W] == FS_SQUASH);

    // R11
    idle_thread_frozen_chk: assert property (@(posedge clk) disable iff (rst)
      !thr_active[t]
      |=> thr_state[t*FS_W +: FS_W] == $past(thr_state[t*FS_W +: FS_W]));

    // R8
    wait_survives_stall_chk: assert property (@(posedge clk) disable iff (rst)
      (thr_active[t] && ctx_stall && !cmt_squash[t] && !rob_squashing[t] &&
       !dec_squash[t] && !resp_valid[t] &&
       thr_state[t*FS_W +: FS_W] == FS_WAIT_RESP)
      |=> thr_state[t*FS_W +: FS_W] == FS_WAIT_RESP);
  end

endmodule

bind fsc_fetch_status fsc_fetch_status_chk #(.NUM_THREADS(NUM_THREADS)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .thr_active    (thr_active),
  .dec_blk       (dec_blk),
  .dec_unblk     (dec_unblk),
  .ren_blk       (ren_blk),
  .ren_unblk     (ren_unblk),
  .exe_blk       (exe_blk),
  .exe_unblk     (exe_unblk),
  .cmt_blk       (cmt_blk),
  .cmt_unblk     (cmt_unblk),
  .cmt_squash    (cmt_squash),
  .rob_squashing (rob_squashing),
  .dec_squash    (dec_squash),
  .ctx_stall     (ctx_stall),
  .resp_valid    (resp_valid),
  .thr_state     (thr_state),
  .status_chg    (status_chg)
);

// File: tb/tb_fsc_fetch_status.sv
`timescale 1ns/1ps
module tb_fsc_fetch_status;

  localparam int NT = 4;
  localparam logic [2:0] S_RUN = 3'd0, S_SQ = 3'd2, S_BLK = 3'd3,
                         S_WAIT = 3'd4, S_ACC = 3'd6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NT-1:0] act = '1;
  logic [NT-1:0] dblk = '0, dunb = '0, rblk = '0, runb = '0;
  logic [NT-1:0] eblk = '0, eunb = '0, cblk = '0, cunb = '0;
  logic [NT-1:0] csq = '0, rsq = '0, dsq = '0;
  logic          ctx = 1'b0;
  logic [NT-1:0] miss = '0, resp = '0, ftry = '0;
  logic [NT*3-1:0] st;
  logic chg, sact;

  always #5 clk = ~clk;

  fsc_fetch_status #(.NUM_THREADS(NT)) dut (
    .clk(clk), .rst(rst), .thr_active(act),
    .dec_blk(dblk), .dec_unblk(dunb), .ren_blk(rblk), .ren_unblk(runb),
    .exe_blk(eblk), .exe_unblk(eunb), .cmt_blk(cblk), .cmt_unblk(cunb),
    .cmt_squash(csq), .rob_squashing(rsq), .dec_squash(dsq),
    .ctx_stall(ctx), .miss_start(miss), .resp_valid(resp),
    .fetch_try(ftry), .thr_state(st), .status_chg(chg),
    .stage_active(sact)
  );

  typedef struct {
    logic [NT*3-1:0] e_st;
    logic            e_chg;
    logic            e_act;
    string           tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [3:0] m_stall [NT];
  logic [2:0] m_st    [NT];

  // reference of the requirements, advanced once per driven cycle
  task automatic cyc(input string tag);
    exp_t it;
    logic any;
    for (int t = 0; t < NT; t++) begin
      logic s_any;
      logic [2:0] cur;
      if (!act[t]) continue;
      m_stall[t] = (m_stall[t] | {cblk[t], eblk[t], rblk[t], dblk[t]})
                   & ~{cunb[t], eunb[t], runb[t], dunb[t]};
      s_any = (|m_stall[t]) | ctx;
      cur = m_st[t];
      if (csq[t])                          begin m_st[t] = S_SQ;  any = 1; end
      else if (rsq[t])                     begin m_st[t] = S_SQ;  any = 1; end
      else if (dsq[t] && cur != S_SQ)      begin m_st[t] = S_SQ;  any = 1; end
      else if (s_any && cur != S_WAIT)     begin m_st[t] = S_BLK; any = 1; end
      else if (cur == S_BLK || cur == S_SQ) begin m_st[t] = S_RUN; any = 1; end
      else if (cur == S_WAIT && resp[t])   begin m_st[t] = s_any ? S_BLK : S_ACC; any = 1; end
      else if (cur == S_ACC && ftry[t])    begin m_st[t] = S_RUN; any = 1; end
      else if (cur == S_RUN && miss[t])    begin m_st[t] = S_WAIT; any = 1; end
    end
    it.e_chg = (any === 1'b1);
    it.e_act = 1'b0;
    for (int t = 0; t < NT; t++) begin
      it.e_st[t*3 +: 3] = m_st[t];
      if (act[t] && (m_st[t] == S_RUN || m_st[t] == S_SQ || m_st[t] == S_ACC))
        it.e_act = 1'b1;
    end
    it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    {dblk, dunb, rblk, runb, eblk, eunb, cblk, cunb} = '0;
    {csq, rsq, dsq, miss, resp, ftry} = '0;
    ctx = 1'b0;
  endtask

  task automatic chk(input string tag, input string what,
                     input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  // monitor: compares each expected item one step after the edge
  always @(posedge clk) begin
    #1;
    if (!rst && q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      for (int t = 0; t < NT; t++)
        chk(it.tag, $sformatf("state t%0d", t), st[t*3 +: 3], it.e_st[t*3 +: 3]);
      chk(it.tag, "status_chg", chg, it.e_chg);
      chk(it.tag, "stage_active", sact, it.e_act);
    end
  end

  initial begin
    for (int t = 0; t < NT; t++) begin m_stall[t] = '0; m_st[t] = S_RUN; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    for (int t = 0; t < NT; t++) chk("R1", "reset state", st[t*3 +: 3], S_RUN);
    chk("R1", "reset status_chg", chg, 0);
    cyc("R1");
    dblk[0] = 1; cyc("R2");
    cyc("R2");
    rblk[0] = 1; cyc("R2");
    dunb[0] = 1; cyc("R2");
    runb[0] = 1; cyc("R2");
    cyc("R7");
    eblk[1] = 1; cblk[2] = 1; cyc("R2");
    eunb[1] = 1; cyc("R2");
    cunb[2] = 1; cyc("R2");
    cyc("R7");
    ctx = 1; cyc("R3");
    cyc("R7");
    csq[0] = 1; dsq[0] = 1; dblk[0] = 1; cyc("R4");
    cyc("R2");
    dunb[0] = 1; cyc("R7");
    rsq[1] = 1; dsq[1] = 1; cyc("R5");
    rsq[1] = 1; eblk[1] = 1; cyc("R5");
    eunb[1] = 1; cyc("R7");
    dsq[2] = 1; cyc("R6");
    dsq[2] = 1; cyc("R6");
    miss[3] = 1; cyc("R8");
    ctx = 1; cyc("R8");
    ctx = 1; resp[3] = 1; cyc("R9");
    cyc("R7");
    miss[3] = 1; cyc("R8");
    resp[3] = 1; cyc("R9");
    cyc("R12");
    ftry[3] = 1; cyc("R10");
    resp[2] = 1; ftry[1] = 1; cyc("R9");
    miss[0] = 1; cyc("R8");
    csq[0] = 1; resp[0] = 1; cyc("R4");
    resp[0] = 1; cyc("R9");
    act = 4'b1101; dblk[1] = 1; cyc("R11");
    csq[1] = 1; cyc("R11");
    act = '1; cyc("R11");
    act = 4'b0001; ctx = 1; cyc("R13");
    cyc("R13");
    act = 4'b0000; csq = '1; cyc("R12");
    act = '1; cyc("R12");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end

endmodule